// File: doc/BRIEF.md
# Complex Lag Correlator Cell

This block is one cross-multiply-and-accumulate cell of an X-F correlator. Two streams of 2-bit samples, X and Y, arrive at one sample pair per clock. Each sample is carried as a sign bit, a magnitude bit and a validity bit. Y passes along a tapped delay line. Each accumulator lane adds the product of the current X sample and one delayed Y sample. The Fourier transform and the long-term integration happen downstream.

X is counter-rotated by a three-level digital phase synthesizer with 32 phase steps, which removes the differential fringe rate. The cell runs either as 32 real lags or as 16 complex lags. Each complex lag has an in-phase lane and a quadrature lane. The starting phase and the phase rate of the synthesizer come from a header word that is captured while a frame runs. That word only takes effect at the next frame-start strobe. On each frame-start strobe the cell copies every accumulator into a readout bank, presents that bank for the next frame, and starts the new frame from zero.

Top module: `lagcor_cell`

## Requirements
- R1: Sample product encoding. The magnitude is 3 when both magnitude bits are 1, and 1 otherwise. The product is negative when the two sign bits differ (sign bit 1 means negative).
- R2: In real mode (`cplx_mode`=0), lane k (k = 0..NLAG-1) adds X(t)·Y(t−k) every cycle that does not carry the frame-start strobe.
- R3: In complex mode, lane 2k adds cos·X(t)·Y(t−k) and lane 2k+1 adds sin·X(t)·Y(t−k), for k = 0..NLAG/2−1.
- R4: The rotator step is the top 5 bits of the phase register. cos is +1 for steps 28..31 and 0..4, −1 for steps 12..20, and 0 for all other steps. sin(step) = cos((step−8) mod 32). Every step has at least one nonzero output.
- R5: On a cycle with the frame-start strobe, the phase register loads the captured header phase and the rate register loads the captured header rate. On every other cycle the phase advances by the rate, modulo 2^PH_W.
- R6: A header captured with `hdr_load` has no effect on the phase or rate until the next frame-start strobe.
- R7: In local validity mode, a lane adds nothing when `x_vld` is 0 or when the Y sample on its tap was marked invalid. The delay line shifts on every cycle regardless. Reset fills the delay line with invalid, all-zero samples.
- R8: In global validity mode, the per-sample validity bits are ignored and `glob_valid` alone decides whether any lane adds.
- R9: Each accumulator saturates at +2^(ACC_W−1)−1 and at −2^(ACC_W−1) instead of wrapping.
- R10: A frame-start strobe at a clock edge copies all accumulators into the readout bank and clears them; the sample of that cycle is not accumulated. `rd_stb` is high for the cycle after that edge. `rd_data` changes only at a strobe edge, so two strobes in a row read out an all-zero frame.
- R11: After reset, `rd_stb` is 0, the readout bank is 0, and the accumulators, phase and rate are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cplx_mode | input | 1 | 1: complex lags, 0: real lags |
| glob_mode | input | 1 | 1: global validity, 0: per-sample validity |
| glob_valid | input | 1 | Cell-wide validity used in global mode |
| x_sgn | input | 1 | X sign bit (1 = negative) |
| x_mag | input | 1 | X magnitude bit (1 = high level) |
| x_vld | input | 1 | X sample validity |
| y_sgn | input | 1 | Y sign bit |
| y_mag | input | 1 | Y magnitude bit |
| y_vld | input | 1 | Y sample validity |
| bocf | input | 1 | Frame-start strobe |
| hdr_load | input | 1 | Captures header phase and rate |
| hdr_phase | input | PH_W | Header starting phase |
| hdr_rate | input | PH_W | Header phase rate |
| rd_stb | output | 1 | Readout bank updated at the last edge |
| rd_data | output | NLAG*ACC_W | Readout bank, lane i at bits [i*ACC_W +: ACC_W], two's complement |

## Verification
The bench feeds the four sign and magnitude combinations and checks them against the R1 encoding; a design that treats a single set magnitude bit as 3 drifts in every lane. Sweeping the phase rate across all 32 steps, with wrap-around, catches an off-by-one in the cos or sin table or a sin with the wrong offset. A header captured in the middle of a frame catches a design that applies the header before the next strobe. Invalid samples sprinkled down the delay line, the global validity override, the cells saturating in both directions and a pair of back-to-back strobes catch, in turn, dropped Y validity, validity bits not overridden, accumulators that wrap, and readouts that include the strobe cycle's sample.

// File: rtl/lagcor_pkg.sv
package lagcor_pkg;

  typedef struct packed {
    logic sgn;
    logic mag;
    logic vld;
  } samp_t;

  typedef logic signed [1:0] tri_t;

  // three-level quantised cosine over 32 steps
  function automatic tri_t rot_level(input logic [4:0] step);
    if (step <= 5'd4 || step >= 5'd28)
      return 2'sb01;
    else if (step >= 5'd12 && step <= 5'd20)
      return 2'sb11;
    else
      return 2'sb00;
  endfunction

  // product of two 2-bit samples, range -3..+3
  function automatic logic signed [2:0] samp_prod(input samp_t a, input samp_t b);
    logic signed [2:0] m;
    m = (a.mag && b.mag) ? 3'sd3 : 3'sd1;
    return (a.sgn ^ b.sgn) ? -m : m;
  endfunction

endpackage

// File: rtl/lagcor_rotator.sv
module lagcor_rotator
  import lagcor_pkg::*;
#(
  parameter int PH_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bocf,
  input  logic            hdr_load,
  input  logic [PH_W-1:0] hdr_phase,
  input  logic [PH_W-1:0] hdr_rate,
  output logic [PH_W-1:0] phase,
  output logic [PH_W-1:0] rate,
  output logic [PH_W-1:0] sh_phase,
  output tri_t            cos_lvl,
  output tri_t            sin_lvl
);
  localparam int STEP_W = 5;

  logic [PH_W-1:0]   sh_rate;
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_phase <= '0;
      sh_rate  <= '0;
      phase    <= '0;
      rate     <= '0;
    end else begin
      if (hdr_load) begin
        sh_phase <= hdr_phase;
        sh_rate  <= hdr_rate;
      end
      if (bocf) begin
        phase <= sh_phase;
        rate  <= sh_rate;
      end else begin
        phase <= phase + rate;
      end
    end
  end

  assign step    = phase[PH_W-1 -: STEP_W];
  assign cos_lvl = rot_level(step);
  assign sin_lvl = rot_level(STEP_W'(step - 5'd8));

endmodule

// File: rtl/lagcor_delay.sv
module lagcor_delay
  import lagcor_pkg::*;
#(
  parameter int NTAP = 32
) (
  input  logic  clk,
  input  logic  rst,
  input  samp_t y_in,
  output samp_t taps [NTAP]
);
  samp_t sr [1:NTAP-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k < NTAP; k++) sr[k] <= '0;
    end else begin
      sr[1] <= y_in;
      for (int k = 2; k < NTAP; k++) sr[k] <= sr[k-1];
    end
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    if (k == 0) begin : g_now
      assign taps[k] = y_in;
    end else begin : g_old
      assign taps[k] = sr[k];
    end
  end

endmodule

// File: rtl/lagcor_lane.sv
module lagcor_lane #(
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bocf,
  input  logic signed [3:0]       delta,
  output logic signed [ACC_W-1:0] acc,
  output logic signed [ACC_W-1:0] rd_val
);
  localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W:0]   sum;
  logic signed [ACC_W-1:0] nxt;

  always_comb begin
    sum = {acc[ACC_W-1], acc} + {{(ACC_W-3){delta[3]}}, delta};
    if (sum[ACC_W] != sum[ACC_W-1])
      nxt = sum[ACC_W] ? MINV : MAXV;
    else
      nxt = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      rd_val <= '0;
    end else if (bocf) begin
      rd_val <= acc;
      acc    <= '0;
    end else begin
      acc <= nxt;
    end
  end

endmodule

// File: rtl/lagcor_cell.sv
module lagcor_cell
  import lagcor_pkg::*;
#(
  parameter int NLAG  = 32,
  parameter int ACC_W = 24,
  parameter int PH_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cplx_mode,
  input  logic                  glob_mode,
  input  logic                  glob_valid,
  input  logic                  x_sgn,
  input  logic                  x_mag,
  input  logic                  x_vld,
  input  logic                  y_sgn,
  input  logic                  y_mag,
  input  logic                  y_vld,
  input  logic                  bocf,
  input  logic                  hdr_load,
  input  logic [PH_W-1:0]       hdr_phase,
  input  logic [PH_W-1:0]       hdr_rate,
  output logic                  rd_stb,
  output logic [NLAG*ACC_W-1:0] rd_data
);
  localparam int NCPX = NLAG / 2;

  samp_t           x_s, y_s;
  samp_t           taps [NLAG];
  logic [PH_W-1:0] rot_phase, rot_rate, rot_sh_phase;
  tri_t            cos_lvl, sin_lvl;

  assign x_s = '{sgn: x_sgn, mag: x_mag, vld: x_vld};
  assign y_s = '{sgn: y_sgn, mag: y_mag, vld: y_vld};

  lagcor_rotator #(.PH_W(PH_W)) rot_i (
    .clk(clk), .rst(rst), .bocf(bocf), .hdr_load(hdr_load),
    .hdr_phase(hdr_phase), .hdr_rate(hdr_rate),
    .phase(rot_phase), .rate(rot_rate), .sh_phase(rot_sh_phase),
    .cos_lvl(cos_lvl), .sin_lvl(sin_lvl)
  );

  lagcor_delay #(.NTAP(NLAG)) dly_i (
    .clk(clk), .rst(rst), .y_in(y_s), .taps(taps)
  );

  for (genvar i = 0; i < NLAG; i++) begin : g_lane
    localparam int KC = i / 2;
    samp_t                   t_s;
    tri_t                    w_cpx, w;
    logic signed [2:0]       p;
    logic signed [3:0]       pe, d;
    logic                    en;
    logic signed [ACC_W-1:0] acc_q, rd_q;

    if ((i % 2) == 0) begin : g_i
      assign w_cpx = cos_lvl;
    end else begin : g_q
      assign w_cpx = sin_lvl;
    end

    always_comb begin
      t_s = cplx_mode ? taps[KC] : taps[i];
      w   = cplx_mode ? w_cpx : 2'sb01;
      p   = samp_prod(x_s, t_s);
      pe  = 4'(p);
      en  = glob_mode ? glob_valid : (x_s.vld && t_s.vld);
      if (!en)
        d = 4'sd0;
      else if (w == 2'sb01)
        d = pe;
      else if (w == 2'sb11)
        d = -pe;
      else
        d = 4'sd0;
    end

    lagcor_lane #(.ACC_W(ACC_W)) lane_i (
      .clk(clk), .rst(rst), .bocf(bocf), .delta(d),
      .acc(acc_q), .rd_val(rd_q)
    );

    assign rd_data[i*ACC_W +: ACC_W] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_stb <= 1'b0;
    else     rd_stb <= bocf;
  end

  if (NCPX * 2 != NLAG) begin : g_bad_nlag
    initial $error("NLAG must be even");
  end

endmodule

// File: rtl/lagcor_cell_chk.sv
module lagcor_cell_chk #(
  parameter int NLAG  = 32,
  parameter int ACC_W = 24,
  parameter int PH_W  = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bocf,
  input logic                  rd_stb,
  input logic [NLAG*ACC_W-1:0] rd_data,
  input logic [PH_W-1:0]       phase,
  input logic [PH_W-1:0]       rate,
  input logic [PH_W-1:0]       sh_phase,
  input logic signed [1:0]     cos_lvl,
  input logic signed [1:0]     sin_lvl
);

  AST_STB_AFTER_BOCF: assert property (@(posedge clk) disable iff (rst)
    bocf |=> rd_stb); // R10

  AST_STB_NEEDS_BOCF: assert property (@(posedge clk) disable iff (rst)
    !bocf |=> !rd_stb); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bocf |=> $stable(rd_data)); // R10

  AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (rst)
    bocf |=> phase == $past(sh_phase)); // R5

  AST_PHASE_ADV: assert property (@(posedge clk) disable iff (rst)
    !bocf |=> phase == PH_W'($past(phase) + $past(rate))); // R5

  AST_ROT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (cos_lvl != 2'sb00) || (sin_lvl != 2'sb00)); // R4

endmodule

bind lagcor_cell lagcor_cell_chk #(.NLAG(NLAG), .ACC_W(ACC_W), .PH_W(PH_W)) chk_i (
  .clk(clk), .rst(rst), .bocf(bocf), .rd_stb(rd_stb), .rd_data(rd_data),
  .phase(rot_phase), .rate(rot_rate), .sh_phase(rot_sh_phase),
  .cos_lvl(cos_lvl), .sin_lvl(sin_lvl)
);

// File: tb/lagcor_cell_tb_top.sv
module lagcor_cell_tb_top;
  localparam int NL = 32;
  localparam int AW = 10;
  localparam int PW = 12;
  localparam int MAXA = (1 << (AW-1)) - 1;
  localparam int MINA = -(1 << (AW-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cplx_mode = 0, glob_mode = 0, glob_valid = 0;
  logic x_sgn = 0, x_mag = 0, x_vld = 0, y_sgn = 0, y_mag = 0, y_vld = 0;
  logic bocf = 0, hdr_load = 0;
  logic [PW-1:0] hdr_phase = '0, hdr_rate = '0;
  logic rd_stb;
  logic [NL*AW-1:0] rd_data;

  always #5 clk = ~clk;

  lagcor_cell #(.NLAG(NL), .ACC_W(AW), .PH_W(PW)) dut_i (
    .clk(clk), .rst(rst), .cplx_mode(cplx_mode), .glob_mode(glob_mode),
    .glob_valid(glob_valid), .x_sgn(x_sgn), .x_mag(x_mag), .x_vld(x_vld),
    .y_sgn(y_sgn), .y_mag(y_mag), .y_vld(y_vld), .bocf(bocf),
    .hdr_load(hdr_load), .hdr_phase(hdr_phase), .hdr_rate(hdr_rate),
    .rd_stb(rd_stb), .rd_data(rd_data)
  );

  int checks = 0, failures = 0;

  // reference model state
  int m_acc [NL];
  int h_s [NL], h_m [NL], h_v [NL];
  int m_ph = 0, m_rt = 0, m_sph = 0, m_srt = 0;
  string cur_tag = "";

  logic [NL*AW-1:0] exp_q [$];
  string            tag_q [$];

  // stimulus staging
  bit b_cpx, b_gm, b_gv, b_xs, b_xm, b_xv, b_ys, b_ym, b_yv, b_bf, b_hl;
  int b_hp, b_hr;

  function automatic int lvl(input int st);
    int s;
    s = st & 31;
    if (s <= 4 || s >= 28) return 1;
    if (s >= 12 && s <= 20) return -1;
    return 0;
  endfunction

  function automatic int clampv(input int v);
    if (v > MAXA) return MAXA;
    if (v < MINA) return MINA;
    return v;
  endfunction

  task automatic step();
    logic [NL*AW-1:0] e;
    @(negedge clk);
    cplx_mode = b_cpx; glob_mode = b_gm; glob_valid = b_gv;
    x_sgn = b_xs; x_mag = b_xm; x_vld = b_xv;
    y_sgn = b_ys; y_mag = b_ym; y_vld = b_yv;
    bocf = b_bf; hdr_load = b_hl;
    hdr_phase = PW'(b_hp); hdr_rate = PW'(b_hr);
    if (b_bf) begin
      for (int i = 0; i < NL; i++) begin
        e[i*AW +: AW] = AW'(m_acc[i]);
        m_acc[i] = 0;
      end
      exp_q.push_back(e);
      tag_q.push_back(cur_tag);
      m_ph = m_sph;
      m_rt = m_srt;
    end else begin
      for (int i = 0; i < NL; i++) begin
        int k, ts, tm, tv, p, w, st;
        bit ok;
        k  = b_cpx ? i/2 : i;
        ts = (k == 0) ? int'(b_ys) : h_s[k];
        tm = (k == 0) ? int'(b_ym) : h_m[k];
        tv = (k == 0) ? int'(b_yv) : h_v[k];
        ok = b_gm ? b_gv : (b_xv && tv != 0);
        p  = ((b_xm && tm != 0) ? 3 : 1) * ((int'(b_xs) != ts) ? -1 : 1);
        st = (m_ph >> (PW-5)) & 31;
        w  = !b_cpx ? 1 : ((i % 2 == 0) ? lvl(st) : lvl(st - 8));
        if (ok) m_acc[i] = clampv(m_acc[i] + w * p);
      end
      m_ph = (m_ph + m_rt) & ((1 << PW) - 1);
    end
    for (int k = NL-1; k >= 2; k--) begin
      h_s[k] = h_s[k-1]; h_m[k] = h_m[k-1]; h_v[k] = h_v[k-1];
    end
    h_s[1] = b_ys; h_m[1] = b_ym; h_v[1] = b_yv;
    if (b_hl) begin
      m_sph = b_hp & ((1 << PW) - 1);
      m_srt = b_hr & ((1 << PW) - 1);
    end
    b_bf = 0;
    b_hl = 0;
  endtask

  task automatic rand_sample(input int inval_pct);
    b_xs = 1'($urandom); b_xm = 1'($urandom);
    b_ys = 1'($urandom); b_ym = 1'($urandom);
    b_xv = ($urandom % 100) >= inval_pct;
    b_yv = ($urandom % 100) >= inval_pct;
  endtask

  task automatic frame_end(input string tg);
    cur_tag = tg;
    b_bf = 1;
    step();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rd_stb) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected readout strobe: actual rd_stb=1 expected 0");
      end else begin
        logic [NL*AW-1:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        for (int i = 0; i < NL; i++) begin
          checks++;
          if (rd_data[i*AW +: AW] !== e[i*AW +: AW]) begin
            failures++;
            $display("FAIL %s lane %0d: actual %0d expected %0d", tg, i,
                     $signed(rd_data[i*AW +: AW]), $signed(e[i*AW +: AW]));
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_acc[i] = 0; h_s[i] = 0; h_m[i] = 0; h_v[i] = 0;
    end
    {b_cpx, b_gm, b_gv, b_xs, b_xm, b_xv, b_ys, b_ym, b_yv, b_bf, b_hl} = '0;
    b_hp = 0; b_hr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R11: reset state
    checks++;
    if (rd_stb !== 1'b0 || rd_data !== '0) begin
      failures++;
      $display("FAIL R11 reset state: actual stb=%0b data=%h expected stb=0 data=0", rd_stb, rd_data);
    end

    // R1: every sign/magnitude combination, real mode, all valid
    b_xv = 1; b_yv = 1;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 16; c++) begin
        {b_xs, b_xm, b_ys, b_ym} = 4'(c);
        step();
      end
    frame_end("R1 product encoding");

    // R2: random real-mode frame
    for (int n = 0; n < 45; n++) begin rand_sample(0); step(); end
    frame_end("R2 real lags");

    // R7: local validity with invalid samples in both streams
    for (int n = 0; n < 50; n++) begin rand_sample(30); step(); end
    frame_end("R7 local validity");

    // R8: global validity overrides per-sample bits; header staged for next frame (R6)
    b_gm = 1;
    for (int n = 0; n < 50; n++) begin
      rand_sample(50);
      b_gv = ($urandom % 4) != 0;
      if (n == 20) begin b_hl = 1; b_hp = 0; b_hr = 128; end
      step();
    end
    frame_end("R8 global validity");
    b_gm = 0;

    // R3 R4 R5: complex mode, rate of one step per cycle sweeps all 32 steps
    b_cpx = 1;
    for (int n = 0; n < 70; n++) begin
      rand_sample(10);
      if (n == 10) begin b_hl = 1; b_hp = 'h5A3; b_hr = 'h3D7; end
      step();
    end
    frame_end("R3 R4 complex sweep");

    // R5 R6: wrapping phase, header reloaded mid-frame must not apply yet
    for (int n = 0; n < 60; n++) begin
      rand_sample(10);
      if (n == 25) begin b_hl = 1; b_hp = 'h800; b_hr = 'hF80; end
      step();
    end
    frame_end("R6 R5 deferred header");

    for (int n = 0; n < 40; n++) begin rand_sample(0); step(); end
    frame_end("R5 negative rate");
    b_cpx = 0;

    // R9: saturate high then low
    b_xv = 1; b_yv = 1; b_xm = 1; b_ym = 1; b_xs = 0; b_ys = 0;
    for (int n = 0; n < 200; n++) step();
    frame_end("R9 positive saturation");
    b_xs = 1;
    for (int n = 0; n < 200; n++) step();
    frame_end("R9 negative saturation");

    // R10: back-to-back strobes give an empty frame
    frame_end("R10 empty frame");
    b_xs = 0;
    step();
    repeat (4) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R10 readouts missing: actual pending=%0d expected 0", exp_q.size());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule